// File: doc/BRIEF.md
# 48-bit Filtered-LFSR Keystream Generator

This block generates a bit-serial keystream for a low-frequency transponder link. A start pulse captures a 48-bit key, a 32-bit serial number and a 32-bit initial vector. Each of these is bit-reversed across its full width. The block seeds a 48-bit shift register from the low slice of the reversed key and the reversed serial number. It then runs a fixed 32-step initialisation, and in each step the output of a nonlinear filter is fed back together with one vector bit and one upper key bit.

Once initialised, the generator returns one keystream bit for each accepted step request. On the same step it XORs that bit onto a serial data bit, which makes it a transcrypt path for encrypting or decrypting frames bit by bit. An optional authentication phase runs directly after initialisation. It consumes the first 32 keystream bits, compares their complement against a received 32-bit authenticator and reports pass or fail. Keystream then continues from the 33rd bit.

Top module: `lfsr_stream_cipher`

## Requirements
- R1: A start pulse loads the state as follows. Bits 47..32 take bits 15..0 of the bit-reversed key, where reversed bit i equals key_in bit 47-i. Bits 31..0 take the bit-reversed serial number. The initial vector is also bit-reversed over its 32 bits.
- R2: Initialisation takes exactly 32 clock cycles after the start edge, and ready first reads high after the 32nd. With auth_mode set, ready first reads high after the 64th cycle.
- R3: In initialisation step i (0..31), the state shifts right by one. The new bit 47 is the filter of the shifted state, XOR reversed-IV bit i, XOR reversed-key bit i+16.
- R4: In a keystream step, the output bit is the filter of the state before the shift. The new bit 47 is the XOR of state bits 0, 2, 3, 6, 7, 8, 16, 22, 23, 26, 30, 41, 42, 43, 46 and 47.
- R5: The filter builds a 5-bit index from five 4-input lookups. Each lookup index is a+2b+4c+8d, taken from its bits in the order listed. Table 0x2C79 serves bits (1,2,4,5) and bits (33,42,43,45). Table 0x6671 serves bits (7,11,13,14), (16,20,22,25) and (27,28,30,32). Index bit g comes from group g in the order just listed. The filter output is bit [index] of 0x7907287B.
- R6: step_en has no effect while ready is low. No ks_valid pulse results, and the keystream that follows is unchanged.
- R7: With ready high, each cycle with step_en high yields ks_valid high in the next cycle together with the next keystream bit. A cycle without step_en leaves the state untouched.
- R8: data_out equals data_in XOR the keystream bit of the same step. When packed into bytes, the first bit is the MSB. A trailing partial byte of n bits uses n keystream bits, placed from the MSB downward.
- R9: With auth_mode set, the expected authenticator is the complement of the first 32 keystream bits. The first bit is compared with auth_ref bit 31, so byte 0 sits in bits 31..24, MSB first. auth_pass is high only on an exact 32-bit match. auth_done is a one-cycle pulse that coincides with ready rising.
- R10: After an authentication phase, the first requested keystream bit is keystream bit 33.
- R11: start takes priority over step_en in the same cycle and restarts initialisation from any phase. ready drops in the next cycle.
- R12: After reset, ready, ks_valid, ks_bit, data_out, auth_done and auth_pass are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and begin initialisation |
| auth_mode | input | 1 | Run the authentication phase after initialisation |
| key_in | input | 48 | Secret key |
| serial_in | input | 32 | Serial number |
| iv_in | input | 32 | Initial vector |
| auth_ref | input | 32 | Received authenticator, first bit in bit 31 |
| step_en | input | 1 | Request one keystream bit |
| data_in | input | 1 | Data bit to transcrypt |
| ready | output | 1 | Keystream mode active |
| ks_valid | output | 1 | ks_bit and data_out carry a new step |
| ks_bit | output | 1 | Last keystream bit |
| data_out | output | 1 | data_in XOR keystream bit |
| auth_done | output | 1 | Authentication result pulse |
| auth_pass | output | 1 | Authentication matched, held until next start |

## Verification
Two functions can land on the same clock edge: a keystream step request and a restarting start pulse. The bench raises both together while ready is high. It requires that no ks_valid follows, that ready drops, and that the stream after the fresh 32-cycle initialisation matches a model seeded only with the new inputs. A second collision is a step request held high through initialisation; it must leave no trace in the first keystream bits. A start issued in the middle of initialisation must likewise restart the count.

// File: rtl/lfsr_cipher_pkg.sv
package lfsr_cipher_pkg;
  localparam int STATE_W  = 48;
  localparam int N_GROUPS = 5;
  localparam int GROUP_IN = 4;

  // first-level lookup tables, second-level 32-entry table
  localparam logic [15:0] LUT_EDGE = 16'h2C79;
  localparam logic [15:0] LUT_MID  = 16'h6671;
  localparam logic [31:0] LUT_TOP  = 32'h7907287B;

  // groups 0 and 4 use the edge table
  localparam logic [N_GROUPS-1:0] EDGE_SEL = 5'b10001;

  // state bit feeding input k of group g sits at TAP_POS[g*GROUP_IN+k]
  localparam int TAP_POS [N_GROUPS*GROUP_IN] = '{
    1, 2, 4, 5,
    7, 11, 13, 14,
    16, 20, 22, 25,
    27, 28, 30, 32,
    33, 42, 43, 45
  };

  // linear feedback taps for keystream mode
  localparam logic [STATE_W-1:0] FB_MASK = 48'hCE00_44C1_01CD;

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_AUTH, PH_RUN} phase_t;
endpackage

// File: rtl/lfsr_nl_filter.sv
module lfsr_nl_filter
  import lfsr_cipher_pkg::*;
(
  input  logic [STATE_W-1:0] st,
  output logic               f_out
);
  logic [N_GROUPS-1:0] mid;
  logic                unused_st;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam logic [15:0] LUT = EDGE_SEL[g] ? LUT_EDGE : LUT_MID;
    logic [GROUP_IN-1:0] idx;
    for (genvar k = 0; k < GROUP_IN; k++) begin : g_in
      assign idx[k] = st[TAP_POS[g*GROUP_IN+k]];
    end
    assign mid[g] = LUT[idx];
  end

  assign f_out     = LUT_TOP[mid];
  assign unused_st = ^st;
endmodule

// File: rtl/lfsr_cipher_core.sv
module lfsr_cipher_core
  import lfsr_cipher_pkg::*;
#(
  parameter int INIT_STEPS = 32,
  parameter int AUTH_STEPS = 32,
  parameter int MIX_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               auth_mode,
  input  logic [STATE_W-1:0] seed,
  input  logic [MIX_W-1:0]   mix,
  input  logic               step_en,
  output logic               ready,
  output logic               ks_now,
  output logic               run_fire,
  output logic               auth_fire,
  output logic               auth_last
);
  localparam int MAXS = (INIT_STEPS > AUTH_STEPS) ? INIT_STEPS : AUTH_STEPS;
  localparam int CW   = (MAXS > 1) ? $clog2(MAXS) : 1;
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_STEPS - 1);
  localparam logic [CW-1:0] AUTH_LAST = CW'(AUTH_STEPS - 1);

  phase_t             phase;
  logic [CW-1:0]      cnt;
  logic [STATE_W-1:0] st;
  logic [MIX_W-1:0]   mix_q;
  logic               auth_q;
  logic               f_pre, f_post, fb;

  lfsr_nl_filter u_f_pre  (.st(st),                        .f_out(f_pre));
  lfsr_nl_filter u_f_post (.st({1'b0, st[STATE_W-1:1]}),   .f_out(f_post));

  assign fb        = ^(st & FB_MASK);
  assign ks_now    = f_pre;
  assign ready     = (phase == PH_RUN);
  assign run_fire  = !start && ready && step_en;
  assign auth_fire = !start && (phase == PH_AUTH);
  assign auth_last = auth_fire && (cnt == AUTH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      st     <= '0;
      mix_q  <= '0;
      auth_q <= 1'b0;
    end else if (start) begin
      phase  <= PH_INIT;
      cnt    <= '0;
      st     <= seed;
      mix_q  <= mix;
      auth_q <= auth_mode;
    end else begin
      unique case (phase)
        PH_INIT: begin
          st    <= {f_post ^ mix_q[0], st[STATE_W-1:1]};
          mix_q <= mix_q >> 1;
          cnt   <= cnt + 1'b1;
          if (cnt == INIT_LAST) begin
            cnt   <= '0;
            phase <= auth_q ? PH_AUTH : PH_RUN;
          end
        end
        PH_AUTH: begin
          st  <= {fb, st[STATE_W-1:1]};
          cnt <= cnt + 1'b1;
          if (cnt == AUTH_LAST) begin
            cnt   <= '0;
            phase <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (step_en) st <= {fb, st[STATE_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  // R2
  ready_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (($past(phase) == PH_INIT && $past(cnt) == INIT_LAST) ||
                      ($past(phase) == PH_AUTH && $past(cnt) == AUTH_LAST)));

  // R11
  start_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase == PH_INIT && cnt == '0 && !ready));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !step_en && !start) |=> $stable(st));
endmodule

// File: rtl/lfsr_auth_cmp.sv
module lfsr_auth_cmp #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] ref_val,
  input  logic         bit_en,
  input  logic         ks,
  input  logic         last,
  output logic         done,
  output logic         pass
);
  logic [N-1:0] ref_q;
  logic         miss;
  logic         miss_n;

  // expected bit is ~ks, so a mismatch is ref bit equal to ks
  assign miss_n = miss | (ref_q[N-1] == ks);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      miss  <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (start) begin
      ref_q <= ref_val;
      miss  <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bit_en) begin
        ref_q <= ref_q << 1;
        miss  <= miss_n;
        if (last) begin
          done <= 1'b1;
          pass <= !miss_n;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/lfsr_stream_cipher.sv
module lfsr_stream_cipher
  import lfsr_cipher_pkg::*;
#(
  parameter int SER_W  = 32,
  parameter int IV_W   = 32,
  parameter int AUTH_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                auth_mode,
  input  logic [STATE_W-1:0]  key_in,
  input  logic [SER_W-1:0]    serial_in,
  input  logic [IV_W-1:0]     iv_in,
  input  logic [AUTH_W-1:0]   auth_ref,
  input  logic                step_en,
  input  logic                data_in,
  output logic                ready,
  output logic                ks_valid,
  output logic                ks_bit,
  output logic                data_out,
  output logic                auth_done,
  output logic                auth_pass
);
  localparam int KEY_W  = STATE_W;
  localparam int SEED_W = STATE_W - SER_W;

  logic [KEY_W-1:0]   key_rev;
  logic [SER_W-1:0]   ser_rev;
  logic [IV_W-1:0]    iv_rev;
  logic [STATE_W-1:0] seed;
  logic [IV_W-1:0]    mix;
  logic               ks_now, run_fire, auth_fire, auth_last;

  for (genvar i = 0; i < KEY_W; i++) begin : g_krev
    assign key_rev[i] = key_in[KEY_W-1-i];
  end
  for (genvar i = 0; i < SER_W; i++) begin : g_srev
    assign ser_rev[i] = serial_in[SER_W-1-i];
  end
  for (genvar i = 0; i < IV_W; i++) begin : g_vrev
    assign iv_rev[i] = iv_in[IV_W-1-i];
  end

  assign seed = {key_rev[SEED_W-1:0], ser_rev};
  assign mix  = iv_rev ^ key_rev[KEY_W-1:SEED_W];

  lfsr_cipher_core #(
    .INIT_STEPS(IV_W),
    .AUTH_STEPS(AUTH_W),
    .MIX_W     (IV_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .auth_mode(auth_mode),
    .seed     (seed),
    .mix      (mix),
    .step_en  (step_en),
    .ready    (ready),
    .ks_now   (ks_now),
    .run_fire (run_fire),
    .auth_fire(auth_fire),
    .auth_last(auth_last)
  );

  lfsr_auth_cmp #(.N(AUTH_W)) u_auth (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ref_val(auth_ref),
    .bit_en (auth_fire),
    .ks     (ks_now),
    .last   (auth_last),
    .done   (auth_done),
    .pass   (auth_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_valid <= 1'b0;
      ks_bit   <= 1'b0;
      data_out <= 1'b0;
    end else begin
      ks_valid <= run_fire;
      if (run_fire) begin
        ks_bit   <= ks_now;
        data_out <= data_in ^ ks_now;
      end
    end
  end

  // R6
  valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> $past(ready && step_en && !start));

  // R9
  auth_done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    auth_done |-> (ready && !$past(ready)));
endmodule

// File: tb/lfsr_stream_cipher_test.sv
module lfsr_stream_cipher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, auth_mode = 1'b0, step_en = 1'b0, data_in = 1'b0;
  logic [47:0] key_in = '0;
  logic [31:0] serial_in = '0, iv_in = '0, auth_ref = '0;
  logic        ready, ks_valid, ks_bit, data_out, auth_done, auth_pass;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;
  logic [47:0] m_st;

  always #5 clk = ~clk;

  lfsr_stream_cipher uut (
    .clk(clk), .rst(rst), .start(start), .auth_mode(auth_mode),
    .key_in(key_in), .serial_in(serial_in), .iv_in(iv_in), .auth_ref(auth_ref),
    .step_en(step_en), .data_in(data_in), .ready(ready), .ks_valid(ks_valid),
    .ks_bit(ks_bit), .data_out(data_out), .auth_done(auth_done), .auth_pass(auth_pass)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model filter built from the requirement text
  function automatic logic bf(input logic [47:0] x);
    logic [15:0] ta = 16'h2C79;
    logic [15:0] tb = 16'h6671;
    logic [31:0] tc = 32'h7907287B;
    logic [4:0]  s;
    s[0] = ta[{x[5],  x[4],  x[2],  x[1]}];
    s[1] = tb[{x[14], x[13], x[11], x[7]}];
    s[2] = tb[{x[25], x[22], x[20], x[16]}];
    s[3] = tb[{x[32], x[30], x[28], x[27]}];
    s[4] = ta[{x[45], x[43], x[42], x[33]}];
    return tc[s];
  endfunction

  function automatic logic m_fb(input logic [47:0] x);
    return x[0]^x[2]^x[3]^x[6]^x[7]^x[8]^x[16]^x[22]^x[23]^x[26]^x[30]
          ^x[41]^x[42]^x[43]^x[46]^x[47];
  endfunction

  function automatic logic [47:0] m_init(input logic [47:0] k, input logic [31:0] s,
                                         input logic [31:0] v);
    logic [47:0] rk, x;
    logic [31:0] rs, rv;
    for (int i = 0; i < 48; i++) rk[i] = k[47-i];
    for (int i = 0; i < 32; i++) begin rs[i] = s[31-i]; rv[i] = v[31-i]; end
    x = {rk[15:0], rs};
    for (int i = 0; i < 32; i++) begin
      x = x >> 1;
      x[47] = bf(x) ^ rv[i] ^ rk[i+16];
    end
    return x;
  endfunction

  task automatic m_next(output logic b);
    b = bf(m_st);
    m_st = {m_fb(m_st), m_st[47:1]};
  endtask

  task automatic launch(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v,
                        input logic am, input logic [31:0] r, input logic se);
    @(negedge clk);
    key_in = k; serial_in = s; iv_in = v; auth_mode = am; auth_ref = r;
    start = 1'b1; step_en = se;
    m_st = m_init(k, s, v);
  endtask

  task automatic wait_ready(input int cyc);
    @(negedge clk);
    start = 1'b0;
    chk("R11 restart drops ready, no step", {62'd0, ks_valid, ready}, 64'd0);
    repeat (cyc - 1) @(negedge clk);
    chk("R2 ready still low", {63'd0, ready}, 64'd0);
    chk("R6 no step while not ready", {63'd0, ks_valid}, 64'd0);
    @(negedge clk);
    chk("R2 ready high on time", {63'd0, ready}, 64'd1);
    chk("R6 no step at ready rise", {63'd0, ks_valid}, 64'd0);
    step_en = 1'b0;
  endtask

  task automatic run_stream(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) begin
      logic e, d, b;
      e = (($urandom % 100) < pct);
      d = $urandom;
      b = 1'b0;
      step_en = e; data_in = d;
      if (e) m_next(b);
      @(negedge clk);
      if (e) begin
        chk("R7 valid after step", {63'd0, ks_valid}, 64'd1);
        chk(tag, {63'd0, ks_bit}, {63'd0, b});
        chk("R8 transcrypt bit", {63'd0, data_out}, {63'd0, d ^ b});
      end else begin
        chk("R7 no valid without step", {63'd0, ks_valid}, 64'd0);
      end
    end
    step_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_ref, plain, got, expv;
    logic [47:0] sv;
    logic b;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {58'd0, ready, ks_valid, ks_bit, data_out, auth_done, auth_pass}, 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R12 idle after reset", {58'd0, ready, ks_valid, ks_bit, data_out, auth_done, auth_pass}, 64'd0);

    // directed: all-zero inputs, then a fixed pattern with step held high in init
    launch(48'h0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    wait_ready(32);
    run_stream(24, 100, "R1 R3 R5 zero seed");
    launch(48'hA5C3_0F1E_7B92, 32'h1357_9BDF, 32'hFEDC_0123, 1'b0, 32'h0, 1'b1);
    wait_ready(32);
    run_stream(32, 70, "R6 R4 stream after ignored steps");

    // random trials
    for (int t = 0; t < 6; t++) begin
      launch({$urandom, $urandom}, $urandom, $urandom, 1'b0, 32'h0, 1'b0);
      wait_ready(32);
      run_stream(40, 60, "R1 R3 R4 R5 keystream");
    end

    // R8 partial byte: 19 bits, packed MSB first
    launch({$urandom, $urandom}, $urandom, $urandom, 1'b0, 32'h0, 1'b0);
    wait_ready(32);
    plain = $urandom; got = '0; expv = '0;
    for (int k = 0; k < 19; k++) begin
      step_en = 1'b1; data_in = plain[31-k];
      m_next(b);
      expv[31-k] = plain[31-k] ^ b;
      @(negedge clk);
      got[31-k] = data_out;
    end
    step_en = 1'b0;
    chk("R8 packed bytes with 3-bit tail", {32'd0, got & 32'hFFFF_E000}, {32'd0, expv & 32'hFFFF_E000});

    // R11 start and step in the same cycle while ready
    launch({$urandom, $urandom}, $urandom, $urandom, 1'b0, 32'h0, 1'b1);
    wait_ready(32);
    run_stream(16, 100, "R11 stream after collision");

    // R11 restart in the middle of initialisation
    launch({$urandom, $urandom}, $urandom, $urandom, 1'b0, 32'h0, 1'b0);
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    launch({$urandom, $urandom}, $urandom, $urandom, 1'b0, 32'h0, 1'b0);
    wait_ready(32);
    run_stream(16, 100, "R11 stream after mid-init restart");

    // R9 / R10 authentication, pass then single-bit mismatch
    for (int t = 0; t < 4; t++) begin
      logic [47:0] k; logic [31:0] s, v, r;
      k = {$urandom, $urandom}; s = $urandom; v = $urandom;
      m_st = m_init(k, s, v);
      for (int j = 0; j < 32; j++) begin m_next(b); exp_ref[31-j] = ~b; end
      sv = m_st;
      r = (t % 2 == 0) ? exp_ref : (exp_ref ^ (32'd1 << ($urandom % 32)));
      launch(k, s, v, 1'b1, r, 1'b0);
      m_st = sv;
      wait_ready(64);
      chk("R9 auth_done with ready", {63'd0, auth_done}, 64'd1);
      chk("R9 auth result", {63'd0, auth_pass}, {63'd0, (t % 2 == 0)});
      @(negedge clk);
      chk("R9 auth_done single pulse", {63'd0, auth_done}, 64'd0);
      chk("R9 auth_pass held", {63'd0, auth_pass}, {63'd0, (t % 2 == 0)});
      run_stream(20, 80, "R10 keystream after auth");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule